// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with Register Port

This block gathers a parameterised set of level-sensitive request lines (96 by default, in banks of 32) into a single interrupt output for a processor. Each source has a mask bit. Software changes the mask bits only through write-one-to-set and write-one-to-clear registers, so no read-modify-write is needed. A pending register for each bank shows which sources are both active and unmasked.

When the output is idle and at least one unmasked source is active, the lowest-numbered such source wins. Its number is held in a sorted register and the output stays high until software writes the acknowledge bit in a control register. Only after that acknowledge does the block pick a new winner. The sorted register also carries a sticky flag that marks a latched request as spurious: the flag is set when the request went inactive, or was masked, before it was acknowledged.

The intended service sequence is: read the sorted number, mask that source, acknowledge, service the device, then unmask. The block also provides a revision register, a soft-reset trigger with a reset-done status bit, and a stored autoidle bit. All registers are 32 bits wide and are reached through a plain address / write-enable / write-data / read-data port. Reads are combinational from the address.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After hardware reset, every mask bit is 1, the interrupt output is low, and the sorted and control registers both read 0.
- R2: The revision register at 0x00 reads the major revision in bits 7:4 and the minor revision in bits 3:0 (0x21 by default). All other bits read 0.
- R3: For bank n, writing to 0x8C+0x20·n sets every mask bit whose data bit is 1, and writing to 0x88+0x20·n clears every mask bit whose data bit is 1. Bits written as 0 are unchanged. Both addresses read back the current mask of that bank.
- R4: The pending register at 0x98+0x20·n reads the bank's source levels ANDed with the inverted mask.
- R5: When the output is idle and any source is pending and unmasked, the output rises on the next clock edge. At the same edge, the number of the lowest-numbered such source is latched into bits 6:0 of the sorted register at 0x40.
- R6: While the output is high, the latched number does not change, even if other sources become pending.
- R7: Writing 1 to bit 0 of the control register at 0x48 lowers the output and clears the sorted register at the write edge. A new winner may then be latched on the following edge.
- R8: If the latched source becomes inactive or masked while it is latched, bits 31:7 of the sorted register read all ones from the next edge until the acknowledge. Viewed from bit 6 upward, this field therefore exceeds 1.
- R9: Writing 1 to bit 1 of the configuration register at 0x10 sets all masks, drops the output, clears the sorted register and the autoidle bit, and lowers bit 0 of the status register at 0x14. That status bit reads 1 again four clock edges after the write edge. After hardware reset it also reads 1 four edges after reset is released.
- R10: Bit 0 of the configuration register is a read/write autoidle bit. Bit 1 always reads 0.
- R11: Writes to the pending, revision, status and sorted registers have no effect. A control write with bit 0 equal to 0 does not acknowledge.
- R12: Source numbers 64 to 95 appear in bits 6:0 of the sorted register with bits 31:7 clear, so bits 31:6 read exactly 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 96 | Level-sensitive request lines, bit k is source k |
| addr_i | input | 12 | Register byte address |
| we_i | input | 1 | Write enable for the current address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the current address (combinational) |
| irq_o | output | 1 | Aggregated interrupt to the processor |

## Verification
A register write takes effect at the clock edge it is presented on. Read data follows the address in the same cycle, so the bench drives inputs after a falling edge and reads one time step later.

The output and the sorted number appear one edge after a source becomes pending. The spurious flag appears one edge after the latched source drops. The bench therefore waits exactly one falling edge after such a change before it reads.

A re-sort after an acknowledge needs the acknowledge edge plus one more. Reset-done needs four edges after the soft-reset edge, so the bench checks the status bit at three edges (expecting 0) and at four edges (expecting 1).

// File: rtl/lic_pkg.sv
// lic_pkg: register offsets and field widths shared by the interrupt
// aggregator. Assumes byte addresses and 32-bit registers.
package lic_pkg;
    localparam int OFS_REV      = 'h000;
    localparam int OFS_SYSCFG   = 'h010;
    localparam int OFS_SYSSTAT  = 'h014;
    localparam int OFS_SORTED   = 'h040;
    localparam int OFS_CTRL     = 'h048;
    localparam int OFS_MCLR0    = 'h088;
    localparam int OFS_MSET0    = 'h08C;
    localparam int OFS_PEND0    = 'h098;
    localparam int BANK_STRIDE  = 'h020;
    // width of the source-number field in the sorted register
    localparam int SORT_NUM_W   = 7;
    // configuration register bit positions
    localparam int CFG_AUTOIDLE = 0;
    localparam int CFG_SOFTRST  = 1;
endpackage

// File: rtl/lic_mask_bank.sv
// lic_mask_bank: one bank of per-source mask bits. Bits are set by a
// set strobe and cleared by a clear strobe, one bit per data bit set
// to 1. Assumes set and clear strobes never coincide (distinct
// addresses). All bits return to 1 on reset or soft clear.
module lic_mask_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] mask_q;

    // mask update: reset to all-masked, otherwise write-one set/clear
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr)  mask_q <= '1;
        else if (set_we)         mask_q <= mask_q | wdata;
        else if (clr_we)         mask_q <= mask_q & ~wdata;
    end

    assign mask_o = mask_q;

    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !soft_clr) |=> ((mask_o & $past(wdata)) == $past(wdata)));
    // R3
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we && !soft_clr) |=> ((mask_o & $past(wdata)) == '0));
endmodule

// File: rtl/lic_prio_sel.sv
// lic_prio_sel: finds the lowest-numbered set bit of a request vector.
// Pure combinational logic; idx_o is 0 when no bit is set.
module lic_prio_sel #(
    parameter int N     = 96,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // scan from the top so the lowest set bit is written last and wins
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/lic_rst_seq.sv
// lic_rst_seq: reset-done sequencer. After hardware reset or a soft
// reset strobe, a counter runs DLY clock edges, then done_o goes high.
module lic_rst_seq #(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    output logic done_o
);
    localparam int CNT_W = $clog2(DLY + 1);
    logic [CNT_W-1:0] cnt_q;

    // count up to DLY, restarting on any reset
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)        cnt_q <= '0;
        else if (cnt_q != CNT_W'(DLY)) cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = (cnt_q == CNT_W'(DLY));

    // R9
    soft_done_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !done_o);
    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !soft_rst) |=> done_o);
endmodule

// File: rtl/lvl_irq_ctrl.sv
// lvl_irq_ctrl: level-sensitive interrupt aggregator with a 32-bit
// register port. Decodes the register map, holds masks per bank,
// latches the lowest pending source until acknowledged, flags a
// spurious latch, and runs a soft reset. Assumes NUM_SRC is a multiple
// of BANK_W and at most 2**SORT_NUM_W sources.
module lvl_irq_ctrl
    import lic_pkg::*;
#(
    parameter int NUM_SRC   = 96,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int REV_MAJOR = 2,
    parameter int REV_MINOR = 1,
    parameter int RST_DLY   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               we_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               irq_o
);
    localparam int NUM_BANK = NUM_SRC / BANK_W;
    localparam int IDX_W    = $clog2(NUM_SRC);
    localparam int FLAG_W   = DATA_W - SORT_NUM_W;

    logic [NUM_SRC-1:0] mask_all;
    logic [NUM_SRC-1:0] eff_pend;
    logic [NUM_BANK-1:0] hit_clr, hit_set, hit_pend;
    logic               any_pend;
    logic [IDX_W-1:0]   win_idx;
    logic               soft_rst, ack_we, cfg_we, rst_done;
    logic               act_q, spur_q, autoidle_q;
    logic [IDX_W-1:0]   num_q;

    // register strobes from the address decoder
    assign cfg_we   = we_i && (addr_i == ADDR_W'(OFS_SYSCFG));
    assign soft_rst = cfg_we && wdata_i[CFG_SOFTRST];
    assign ack_we   = we_i && (addr_i == ADDR_W'(OFS_CTRL)) && wdata_i[0];

    // one mask bank and its address hits per bank
    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        assign hit_clr[b]  = (addr_i == ADDR_W'(OFS_MCLR0 + b * BANK_STRIDE));
        assign hit_set[b]  = (addr_i == ADDR_W'(OFS_MSET0 + b * BANK_STRIDE));
        assign hit_pend[b] = (addr_i == ADDR_W'(OFS_PEND0 + b * BANK_STRIDE));

        lic_mask_bank #(.W(BANK_W)) u_mask (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_clr (soft_rst),
            .set_we   (we_i && hit_set[b]),
            .clr_we   (we_i && hit_clr[b]),
            .wdata    (wdata_i[BANK_W-1:0]),
            .mask_o   (mask_all[b*BANK_W +: BANK_W])
        );
    end

    assign eff_pend = src_i & ~mask_all;

    lic_prio_sel #(.N(NUM_SRC), .IDX_W(IDX_W)) u_sel (
        .req_i (eff_pend),
        .any_o (any_pend),
        .idx_o (win_idx)
    );

    lic_rst_seq #(.DLY(RST_DLY)) u_rseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .done_o   (rst_done)
    );

    // sort latch: capture winner when idle, hold until acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            act_q  <= 1'b0;
            num_q  <= '0;
            spur_q <= 1'b0;
        end else if (ack_we) begin
            act_q  <= 1'b0;
            num_q  <= '0;
            spur_q <= 1'b0;
        end else if (!act_q) begin
            if (any_pend) begin
                act_q <= 1'b1;
                num_q <= win_idx;
            end
        end else if (!eff_pend[num_q]) begin
            spur_q <= 1'b1;
        end
    end

    // autoidle bit: plain stored configuration bit
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) autoidle_q <= 1'b0;
        else if (cfg_we)        autoidle_q <= wdata_i[CFG_AUTOIDLE];
    end

    assign irq_o = act_q;

    // read mux: fixed registers first, then per-bank registers
    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADDR_W'(OFS_REV):     rdata_o[7:0] = {4'(REV_MAJOR), 4'(REV_MINOR)};
            ADDR_W'(OFS_SYSCFG):  rdata_o[CFG_AUTOIDLE] = autoidle_q;
            ADDR_W'(OFS_SYSSTAT): rdata_o[0] = rst_done;
            ADDR_W'(OFS_SORTED):
                if (act_q) rdata_o = {{FLAG_W{spur_q}}, SORT_NUM_W'(num_q)};
            default: ;
        endcase
        for (int b = 0; b < NUM_BANK; b++) begin
            if (hit_clr[b] || hit_set[b])
                rdata_o[BANK_W-1:0] = mask_all[b*BANK_W +: BANK_W];
            else if (hit_pend[b])
                rdata_o[BANK_W-1:0] = eff_pend[b*BANK_W +: BANK_W];
        end
    end

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(any_pend));
    // R6
    num_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !ack_we && !soft_rst) |=> (act_q && $stable(num_q)));
    // R7
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_we |=> !irq_o);
    // R8
    spur_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !eff_pend[num_q] && !ack_we && !soft_rst) |=> spur_q);
    // R9
    soft_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!irq_o && (mask_all == '1)));
endmodule

// File: tb/lvl_irq_ctrl_tb.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_tb;
    localparam int A_REV = 'h000, A_CFG = 'h010, A_STAT = 'h014,
                   A_SORT = 'h040, A_CTRL = 'h048;

    function automatic int a_mclr(int n); return 'h88 + 'h20 * n; endfunction
    function automatic int a_mset(int n); return 'h8C + 'h20 * n; endfunction
    function automatic int a_pend(int n); return 'h98 + 'h20 * n; endfunction

    // reset-state table: {address, expected read value}
    localparam logic [43:0] RST_VEC [11] = '{
        {12'h000, 32'h0000_0021},
        {12'h010, 32'h0000_0000},
        {12'h014, 32'h0000_0001},
        {12'h040, 32'h0000_0000},
        {12'h048, 32'h0000_0000},
        {12'h08C, 32'hFFFF_FFFF},
        {12'h0AC, 32'hFFFF_FFFF},
        {12'h0CC, 32'hFFFF_FFFF},
        {12'h098, 32'h0000_0000},
        {12'h0B8, 32'h0000_0000},
        {12'h0D8, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] src_i = '0;
    logic [11:0] addr_i = '0;
    logic        we_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o;
    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    lvl_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .addr_i(addr_i),
        .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // one write, applied at the next rising edge; returns at the negedge after
    task automatic wr(int a, logic [31:0] d);
        addr_i = 12'(a); wdata_i = d; we_i = 1'b1;
        @(negedge clk);
        we_i = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        addr_i = 12'(a); we_i = 1'b0;
        #1 d = rdata_o;
    endtask

    task automatic rd_chk(string req, int a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R9: reset-done low right after release
        rd_chk("R9", A_STAT, 32'h0);
        repeat (3) tick();
        rd_chk("R9", A_STAT, 32'h0);
        tick();
        // R1 R2 R4 R9 R10: reset-state table
        foreach (RST_VEC[i]) rd_chk("R1", int'(RST_VEC[i][43:32]), RST_VEC[i][31:0]);
        check("R1", 32'(irq_o), 32'h0);

        // R3: write-one clear / set on bank 1, zeros leave bits alone
        wr(a_mclr(1), 32'h0000_00F0);
        rd_chk("R3", a_mset(1), 32'hFFFF_FF0F);
        wr(a_mset(1), 32'h0000_0010);
        rd_chk("R3", a_mclr(1), 32'hFFFF_FF1F);
        wr(a_mclr(1), 32'h0);
        rd_chk("R3", a_mset(1), 32'hFFFF_FF1F);
        rd_chk("R3", a_mset(0), 32'hFFFF_FFFF);

        // R4: sources 33, 36, 37 raised; only 37 is unmasked
        src_i = '0; src_i[33] = 1'b1; src_i[36] = 1'b1; src_i[37] = 1'b1;
        tick();
        rd_chk("R4", a_pend(1), 32'h0000_0020);
        rd_chk("R4", a_pend(0), 32'h0);
        // R5: latched one edge after it became pending
        check("R5", 32'(irq_o), 32'h1);
        rd_chk("R5", A_SORT, 32'd37);

        // R8: latched source drops -> flag in bits 31:7
        src_i = '0;
        tick();
        rd(A_SORT, rv);
        check("R8", rv, 32'hFFFF_FFA5);
        check("R8", 32'(rv >> 6) > 1 ? 32'h1 : 32'h0, 32'h1);
        check("R6", 32'(irq_o), 32'h1);
        // R7: acknowledge drops output and clears sorted register
        wr(A_CTRL, 32'h1);
        check("R7", 32'(irq_o), 32'h0);
        rd_chk("R7", A_SORT, 32'h0);

        // R5: unmask everything, lowest of 40 and 70 wins
        wr(a_mclr(0), 32'hFFFF_FFFF);
        wr(a_mclr(1), 32'hFFFF_FFFF);
        wr(a_mclr(2), 32'hFFFF_FFFF);
        src_i[40] = 1'b1; src_i[70] = 1'b1;
        tick();
        rd_chk("R5", A_SORT, 32'd40);
        // R6: a lower source arriving later does not replace the latch
        src_i[3] = 1'b1;
        tick(); tick();
        rd_chk("R6", A_SORT, 32'd40);
        // R7: acknowledge, then the next edge re-sorts to source 3
        wr(A_CTRL, 32'h1);
        check("R7", 32'(irq_o), 32'h0);
        tick();
        rd_chk("R7", A_SORT, 32'd3);
        // R11: control write without bit 0 does not acknowledge
        wr(A_CTRL, 32'hFFFF_FFFE);
        rd_chk("R11", A_SORT, 32'd3);
        check("R11", 32'(irq_o), 32'h1);
        // R8: masking the latched source also flags spurious
        wr(a_mset(0), 32'h0000_0008);
        tick();
        rd_chk("R8", A_SORT, 32'hFFFF_FF83);
        wr(A_CTRL, 32'h1);
        tick();
        rd_chk("R5", A_SORT, 32'd40);
        // R12: source 70 carries a plain number with bit 6 set
        wr(a_mset(1), 32'h0000_0100);
        wr(A_CTRL, 32'h1);
        tick();
        rd(A_SORT, rv);
        check("R12", rv, 32'h0000_0046);
        check("R12", rv >> 6, 32'h1);

        // R11: writes to read-only registers change nothing
        wr(a_pend(2), 32'hFFFF_FFFF);
        wr(A_REV, 32'h0);
        wr(A_STAT, 32'h0);
        wr(A_SORT, 32'h0);
        rd_chk("R11", a_pend(2), 32'h0000_0040);
        rd_chk("R11", a_mset(2), 32'h0);
        rd_chk("R11", A_REV, 32'h0000_0021);
        rd_chk("R11", A_SORT, 32'h0000_0046);

        // R10: autoidle bit read/write
        wr(A_CFG, 32'h1);
        rd_chk("R10", A_CFG, 32'h1);

        // R9: soft reset
        wr(A_CFG, 32'h2);
        rd_chk("R9", A_STAT, 32'h0);
        rd_chk("R9", a_mset(1), 32'hFFFF_FFFF);
        rd_chk("R9", A_SORT, 32'h0);
        rd_chk("R10", A_CFG, 32'h0);
        check("R9", 32'(irq_o), 32'h0);
        repeat (3) tick();
        rd_chk("R9", A_STAT, 32'h0);
        tick();
        rd_chk("R9", A_STAT, 32'h1);
        check("R9", 32'(irq_o), 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule